// File: doc/BRIEF.md
# CSI-2 Image Data-Type Filter

This block sits behind a CSI-2 packet header decoder. The decoder gives it one header strobe per packet, carrying the 6-bit data type and the 16-bit word count. For long packets the payload bytes follow as a valid/ready stream, with a last-byte marker. The block turns the frame-start and frame-end short packets into single-cycle frame boundary strobes. It forwards the payload of image lines to a downstream byte stream that marks the start of frame and the end of each line. Everything else that arrives inside a frame is discarded without stalling the input. This covers embedded data, null packets and user-defined packets, whatever their number.

Software programs three working values:
- a filter enable,
- an image data-type register,
- a packed resolution word.

None of them acts until an update request is made. The block then copies all three into its active set at the next frame start. Against the active set it checks every forwarded line's word count and the number of forwarded lines per frame. The two results are held as error flags until the next frame start. A free-running frame counter advances once per frame.

Top module: `csi_dtf`

## Requirements
- R1: A header with data type 0x00 (frame start) gives a one-cycle `frame_start` pulse in the cycle after the header strobe. A header with data type 0x01 (frame end) gives a one-cycle `frame_end` pulse in the cycle after its header strobe. Short packets (data type below 0x10) never produce output beats.
- R2: With the active filter enable set, a long packet is forwarded only when its data type equals bits 7:2 of the active data-type register. Bits 1:0 of that register are ignored. Embedded data (0x12), null (0x10) and user-defined 8-bit (0x37) packets are dropped, however many of them a frame carries.
- R3: With the active filter enable clear, every long packet (data type 0x10 or above) is forwarded.
- R4: Bytes of a dropped packet produce no output beat, and `in_ready` is high for them whatever the state of `out_ready`.
- R5: For a forwarded packet:
  - `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and the bytes pass unchanged and in order.
  - `out_eol` is set with the packet's last byte.
  - `out_sof` is set with the first forwarded byte after a frame start, and with no other byte.
- R6: Changes to the working filter enable, data type or resolution have no effect on their own. A pulse on `cfg_upd_req` raises `upd_pending`. At the next frame-start header all three values are copied to the active set and `upd_pending` clears. A request in the same cycle as a frame-start header is applied at that frame start.
- R7: The resolution word holds the line count in bits 31:16 and the pixels per line in bits 15:0. `err_len` is set when a forwarded packet's word count differs from floor(pixels × 3 / 2). It stays set until the next frame start, which clears it.
- R8: At a frame-end header, `err_lines` is set if the number of packets forwarded since the frame start differs from the active line count. It is cleared at the next frame start.
- R9: `frame_count` increases by one at each frame-start header. The new value is visible in the same cycle as `frame_start`, and the count wraps at its width.
- R10: After reset, `frame_count`, `err_len`, `err_lines`, `upd_pending` and `out_valid` are 0. The active set then holds filter enabled, data type 0x2C and a resolution of 1080 lines of 1920 pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_filt_en | input | 1 | Working filter enable |
| cfg_dt_reg | input | 8 | Working data-type register, data type in bits 7:2 |
| cfg_res | input | 32 | Working resolution: lines in 31:16, pixels in 15:0 |
| cfg_upd_req | input | 1 | Pulse: copy working values at the next frame start |
| upd_pending | output | 1 | Update request waiting for a frame start |
| hdr_valid | input | 1 | Packet header strobe |
| hdr_dt | input | 6 | Packet data type |
| hdr_wc | input | 16 | Packet word count |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Last payload byte of the packet |
| in_ready | output | 1 | Payload byte accepted |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_sof | output | 1 | First forwarded byte of a frame |
| out_eol | output | 1 | Last byte of a forwarded line |
| out_ready | input | 1 | Downstream ready |
| frame_start | output | 1 | Frame-start strobe |
| frame_end | output | 1 | Frame-end strobe |
| frame_count | output | 16 | Frames received |
| err_len | output | 1 | Line-length error, held until the next frame start |
| err_lines | output | 1 | Line-count error, held until the next frame start |

## Verification
Two functions can act in the same cycle. The first pair is an update request and the frame-start header that applies it. The bench raises `cfg_upd_req` in the very cycle of a frame-start header and then expects that frame to be filtered with the new settings. It also checks that `upd_pending` is already low when `frame_start` appears. The second pair is the clearing of the sticky error flags and the frame start that follows a faulty frame. The bench builds frames with too few lines and with an over-long line, checks that the flags are set after the frame end, and checks that they are low in the `frame_start` cycle of the next frame.

// File: rtl/csi_dtf_pkg.sv
package csi_dtf_pkg;

    localparam int DT_W   = 6;
    localparam int WC_W   = 16;
    localparam int RES_W  = 16;
    localparam int BYTE_W = 8;

    localparam logic [DT_W-1:0] DT_FRAME_START = 6'h00;
    localparam logic [DT_W-1:0] DT_FRAME_END   = 6'h01;
    localparam logic [DT_W-1:0] DT_LONG_FIRST  = 6'h10;

    typedef enum logic [1:0] {
        PK_FS,
        PK_FE,
        PK_LONG,
        PK_SHORT_OTHER
    } pkt_kind_t;

    typedef struct packed {
        logic             filt_en;
        logic [DT_W-1:0]  dt;
        logic [RES_W-1:0] lines;
        logic [RES_W-1:0] pixels;
    } dtf_cfg_t;

    function automatic pkt_kind_t classify(input logic [DT_W-1:0] dt);
        if (dt == DT_FRAME_START)     return PK_FS;
        else if (dt == DT_FRAME_END)  return PK_FE;
        else if (dt >= DT_LONG_FIRST) return PK_LONG;
        else                          return PK_SHORT_OTHER;
    endfunction

    // Word count of a line of packed 12-bit pixels: floor(pixels * 3 / 2).
    function automatic logic [WC_W-1:0] raw12_wc(input logic [RES_W-1:0] pixels);
        logic [RES_W+1:0] triple;
        triple = {2'b00, pixels} + {1'b0, pixels, 1'b0};
        return triple[WC_W:1];
    endfunction

endpackage

// File: rtl/csi_dtf_shadow.sv
module csi_dtf_shadow
    import csi_dtf_pkg::*;
#(
    parameter dtf_cfg_t RST_CFG = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load_evt,
    input  logic     upd_req,
    input  dtf_cfg_t work_cfg,
    output dtf_cfg_t act_cfg,
    output logic     pending
);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cfg <= RST_CFG;
            pending <= 1'b0;
        end else if (load_evt && (pending || upd_req)) begin
            act_cfg <= work_cfg;
            pending <= 1'b0;
        end else if (upd_req) begin
            pending <= 1'b1;
        end
    end

    // R6
    shadow_at_fs_chk: assert property (@(posedge clk) disable iff (rst)
        (act_cfg != $past(act_cfg)) |-> $past(load_evt));

endmodule

// File: rtl/csi_dtf_frmchk.sv
module csi_dtf_frmchk
    import csi_dtf_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int LINE_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fs_evt,
    input  logic             fe_evt,
    input  logic             fwd_evt,
    input  logic [WC_W-1:0]  wc,
    input  logic [RES_W-1:0] exp_lines,
    input  logic [WC_W-1:0]  exp_wc,
    output logic             frame_start,
    output logic             frame_end,
    output logic [CNT_W-1:0] frame_count,
    output logic             err_len,
    output logic             err_lines
);

    logic [LINE_W-1:0] line_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            frame_count <= '0;
            line_cnt    <= '0;
            err_len     <= 1'b0;
            err_lines   <= 1'b0;
        end else begin
            frame_start <= fs_evt;
            frame_end   <= fe_evt;
            if (fs_evt) begin
                frame_count <= frame_count + 1'b1;
                line_cnt    <= '0;
                err_len     <= 1'b0;
                err_lines   <= 1'b0;
            end else begin
                if (fwd_evt) begin
                    line_cnt <= line_cnt + 1'b1;
                    if (wc != exp_wc) err_len <= 1'b1;
                end
                if (fe_evt && (RES_W'(line_cnt) != exp_lines)) err_lines <= 1'b1;
            end
        end
    end

    // R9
    frame_count_step_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> frame_count == CNT_W'($past(frame_count) + 1'b1));

    // R7, R8
    flags_clear_at_fs_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (!err_len && !err_lines));

    // R1
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(frame_start && frame_end));

endmodule

// File: rtl/csi_dtf.sv
module csi_dtf
    import csi_dtf_pkg::*;
#(
    parameter int          CNT_W      = 16,
    parameter logic [7:0]  DEF_DT_REG = 8'hB0,
    parameter logic [31:0] DEF_RES    = 32'h0438_0780,
    parameter bit          DEF_FILT   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_filt_en,
    input  logic [7:0]        cfg_dt_reg,
    input  logic [31:0]       cfg_res,
    input  logic              cfg_upd_req,
    output logic              upd_pending,
    input  logic              hdr_valid,
    input  logic [DT_W-1:0]   hdr_dt,
    input  logic [WC_W-1:0]   hdr_wc,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eol,
    input  logic              out_ready,
    output logic              frame_start,
    output logic              frame_end,
    output logic [CNT_W-1:0]  frame_count,
    output logic              err_len,
    output logic              err_lines
);

    localparam dtf_cfg_t RST_CFG = '{
        filt_en: DEF_FILT,
        dt:      DEF_DT_REG[7:2],
        lines:   DEF_RES[31:16],
        pixels:  DEF_RES[15:0]
    };

    dtf_cfg_t  work_cfg, act_cfg;
    pkt_kind_t kind;
    logic      fs_evt, fe_evt, pass_evt;
    logic      fwd_q, sof_pend;

    assign work_cfg = '{
        filt_en: cfg_filt_en,
        dt:      cfg_dt_reg[7:2],
        lines:   cfg_res[31:16],
        pixels:  cfg_res[15:0]
    };

    assign kind     = classify(hdr_dt);
    assign fs_evt   = hdr_valid && (kind == PK_FS);
    assign fe_evt   = hdr_valid && (kind == PK_FE);
    assign pass_evt = hdr_valid && (kind == PK_LONG) &&
                      (!act_cfg.filt_en || (hdr_dt == act_cfg.dt));

    csi_dtf_shadow #(.RST_CFG(RST_CFG)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .load_evt (fs_evt),
        .upd_req  (cfg_upd_req),
        .work_cfg (work_cfg),
        .act_cfg  (act_cfg),
        .pending  (upd_pending)
    );

    csi_dtf_frmchk #(.CNT_W(CNT_W), .LINE_W(RES_W)) u_frmchk (
        .clk         (clk),
        .rst         (rst),
        .fs_evt      (fs_evt),
        .fe_evt      (fe_evt),
        .fwd_evt     (pass_evt),
        .wc          (hdr_wc),
        .exp_lines   (act_cfg.lines),
        .exp_wc      (raw12_wc(act_cfg.pixels)),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .frame_count (frame_count),
        .err_len     (err_len),
        .err_lines   (err_lines)
    );

    // Forward/drop decision held for the payload that follows the header.
    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_q    <= 1'b0;
            sof_pend <= 1'b0;
        end else begin
            if (hdr_valid) fwd_q <= pass_evt;
            if (fs_evt) sof_pend <= 1'b1;
            else if (out_valid && out_ready) sof_pend <= 1'b0;
        end
    end

    assign out_valid = in_valid && fwd_q;
    assign out_data  = in_data;
    assign out_eol   = out_valid && in_last;
    assign out_sof   = out_valid && sof_pend;
    assign in_ready  = fwd_q ? out_ready : 1'b1;

    // R4
    drop_never_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !out_valid) |-> in_ready);

    // R6
    pending_clear_at_fs_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> !upd_pending);

    // R5
    sof_once_chk: assert property (@(posedge clk) disable iff (rst)
        (out_sof && out_ready) |=> !out_sof);

endmodule

// File: tb/csi_dtf_test.sv
module csi_dtf_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_filt_en;
    logic [7:0]  cfg_dt_reg;
    logic [31:0] cfg_res;
    logic        cfg_upd_req;
    logic        upd_pending;
    logic        hdr_valid;
    logic [5:0]  hdr_dt;
    logic [15:0] hdr_wc;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_last;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_sof;
    logic        out_eol;
    logic        out_ready;
    logic        frame_start;
    logic        frame_end;
    logic [15:0] frame_count;
    logic        err_len;
    logic        err_lines;

    always #5 clk = ~clk;

    csi_dtf uut (
        .clk(clk), .rst(rst),
        .cfg_filt_en(cfg_filt_en), .cfg_dt_reg(cfg_dt_reg), .cfg_res(cfg_res),
        .cfg_upd_req(cfg_upd_req), .upd_pending(upd_pending),
        .hdr_valid(hdr_valid), .hdr_dt(hdr_dt), .hdr_wc(hdr_wc),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol),
        .out_ready(out_ready),
        .frame_start(frame_start), .frame_end(frame_end), .frame_count(frame_count),
        .err_len(err_len), .err_lines(err_lines)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit bp_en  = 1'b0;

    logic [9:0] exp_q[$];

    // Bench model of the working and active configuration.
    bit         w_filt = 1'b1, m_filt = 1'b1;
    logic [5:0] w_dt = 6'h2C,  m_dt = 6'h2C;
    bit         m_pend = 1'b0;
    bit         m_first = 1'b0;
    logic [15:0] exp_fc = '0;
    logic [7:0]  seed = 8'h11;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Downstream ready: steady high, or a repeating stall pattern.
    initial begin
        int cyc;
        cyc = 0;
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            out_ready = bp_en ? ((cyc % 4) != 1 && (cyc % 7) != 3) : 1'b1;
        end
    end

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected output beat", int'(out_data), 0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk({out_data, out_sof, out_eol} == e, "R5 forwarded beat",
                    int'({out_data, out_sof, out_eol}), int'(e));
            end
        end
    end

    task automatic hdr(input logic [5:0] dt, input logic [15:0] wc, input bit req);
        hdr_valid   = 1'b1;
        hdr_dt      = dt;
        hdr_wc      = wc;
        cfg_upd_req = req;
        @(posedge clk);
        #1;
        hdr_valid   = 1'b0;
        cfg_upd_req = 1'b0;
    endtask

    task automatic set_work(input bit f, input logic [7:0] dtr, input logic [31:0] res);
        cfg_filt_en = f;
        cfg_dt_reg  = dtr;
        cfg_res     = res;
        w_filt      = f;
        w_dt        = dtr[7:2];
    endtask

    task automatic request_update();
        cfg_upd_req = 1'b1;
        @(posedge clk);
        #1;
        cfg_upd_req = 1'b0;
        m_pend = 1'b1;
        @(negedge clk);
        chk(upd_pending == 1'b1, "R6 pending after request", int'(upd_pending), 1);
        @(posedge clk);
        #1;
    endtask

    task automatic send_fs(input bit req);
        if (m_pend || req) begin
            m_filt = w_filt;
            m_dt   = w_dt;
        end
        m_pend  = 1'b0;
        m_first = 1'b1;
        exp_fc  = exp_fc + 1'b1;
        hdr(6'h00, 16'd0, req);
        @(negedge clk);
        chk(frame_start == 1'b1, "R1 frame_start pulse", int'(frame_start), 1);
        chk(frame_count == exp_fc, "R9 frame counter", int'(frame_count), int'(exp_fc));
        chk(upd_pending == 1'b0, "R6 pending cleared at frame start", int'(upd_pending), 0);
        chk(!err_len && !err_lines, "R7 R8 flags cleared at frame start",
            int'({err_len, err_lines}), 0);
        @(posedge clk);
        #1;
        chk(frame_start == 1'b0, "R1 frame_start one cycle", int'(frame_start), 0);
    endtask

    task automatic send_fe();
        hdr(6'h01, 16'd0, 1'b0);
        @(negedge clk);
        chk(frame_end == 1'b1, "R1 frame_end pulse", int'(frame_end), 1);
    endtask

    task automatic send_long(input logic [5:0] dt, input int wc);
        bit fwd;
        fwd = (dt >= 6'h10) && (!m_filt || dt == m_dt);
        hdr(dt, 16'(wc), 1'b0);
        for (int i = 0; i < wc; i++) begin
            in_valid = 1'b1;
            in_data  = seed + 8'(i);
            in_last  = (i == wc - 1);
            if (fwd) exp_q.push_back({in_data, m_first && (i == 0), in_last});
            @(negedge clk);
            if (!fwd) begin
                chk(in_ready == 1'b1 && out_valid == 1'b0, "R4 dropped byte accepted silently",
                    int'({in_ready, out_valid}), 2);
            end
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (fwd) m_first = 1'b0;
        seed = seed + 8'h1D;
    endtask

    task automatic send_frame(input int nud, input int nimg, input int badline, input bit req);
        send_fs(req);
        send_long(6'h12, 3);
        send_long(6'h10, 6);
        for (int u = 0; u < nud; u++) send_long(6'h37, 6);
        for (int l = 0; l < nimg; l++) send_long(6'h2C, (l == badline) ? 8 : 6);
        send_fe();
    endtask

    task automatic check_flags(input bit el, input bit ec, input string tag);
        chk(err_len == el, {tag, " err_len"}, int'(err_len), int'(el));
        chk(err_lines == ec, {tag, " err_lines"}, int'(err_lines), int'(ec));
        chk(exp_q.size() == 0, {tag, " all expected beats seen"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        hdr_valid = 1'b0; hdr_dt = '0; hdr_wc = '0;
        in_valid = 1'b0; in_data = '0; in_last = 1'b0;
        cfg_upd_req = 1'b0;
        set_work(1'b1, 8'hB0, 32'h0438_0780);
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R10
        chk(frame_count == 0 && !err_len && !err_lines && !upd_pending && !out_valid,
            "R10 reset state", int'({frame_count, err_len, err_lines, upd_pending, out_valid}), 0);
        @(posedge clk);
        #1;

        // R6/R7: program 4 lines of 4 pixels (word count 6) and apply.
        set_work(1'b1, 8'hB0, 32'h0004_0004);
        request_update();
        send_frame(10, 4, -1, 1'b0);
        check_flags(1'b0, 1'b0, "R2 frame with ten user packets");

        // R2/R4/R5: fewer user packets, downstream stalls.
        bp_en = 1'b1;
        send_frame(4, 4, -1, 1'b0);
        check_flags(1'b0, 1'b0, "R2 frame with four user packets under backpressure");

        // R6: working filter change without request has no effect.
        set_work(1'b0, 8'hB0, 32'h0004_0004);
        send_frame(2, 4, -1, 1'b0);
        check_flags(1'b0, 1'b0, "R6 unrequested change ignored");

        // R3/R6: request in the frame-start cycle; everything long forwarded.
        send_frame(2, 4, -1, 1'b1);
        check_flags(1'b1, 1'b1, "R3 filter off forwards all long packets");

        // R2: another data type, bits 1:0 of the register set.
        set_work(1'b1, 8'hAF, 32'h0004_0004);
        request_update();
        send_fs(1'b0);
        send_long(6'h12, 3);
        send_long(6'h2C, 6);
        send_long(6'h2C, 6);
        for (int l = 0; l < 4; l++) send_long(6'h2B, 6);
        send_fe();
        check_flags(1'b0, 1'b0, "R2 other data type selected");

        // R8: too few lines.
        set_work(1'b1, 8'hB0, 32'h0004_0004);
        request_update();
        send_frame(3, 3, -1, 1'b0);
        check_flags(1'b0, 1'b1, "R8 short frame");

        // R7: one over-long line.
        bp_en = 1'b0;
        send_frame(1, 4, 2, 1'b0);
        check_flags(1'b1, 1'b0, "R7 long line");

        // R7/R8: flags cleared by the following frame start (checked in send_fs).
        send_frame(0, 4, -1, 1'b0);
        check_flags(1'b0, 1'b0, "R7 R8 clean frame after errors");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule